// File: doc/BRIEF.md
# Endpoint Base Address Register Bank

This block is the configuration-space register file that holds an endpoint's six base address slots and its expansion ROM base register. System software reaches it through a dword-addressed configuration port with per-byte-lane enables. Each slot is set up by parameters: whether it is unused, a 32-bit memory window, a 64-bit memory window or an I/O window, whether the memory is prefetchable, and its size as a power of two. The block forces the hardwired attribute and alignment bits on every read. A write of all ones therefore reads back the size mask, which is how enumeration software learns how much address space each window needs.

Two neighbouring slots that form a 64-bit window are joined into a single 64-bit base. The programmed bases, the size of each window, the ROM base, the ROM enable and the ROM size are exported as plain outputs for an address decoder. Indices that are not slots of this bank read as zero, so the rest of the configuration header can be merged over the read data with a simple OR. Parameter sets that describe an impossible layout stop elaboration.

Top module: `ep_bar_bank`

## Requirements
- R1: Slot n (n = 0..5) sits at dword index 4+n (byte offsets 10h to 24h). The ROM register sits at dword index 12 (byte offset 30h). Any other index reads 0000_0000h, and a write to it changes no register.
- R2: Bit 0 of a slot is read-only. It reads 1 for an I/O slot and 0 for a memory slot.
- R3: On a memory slot, bits [2:1] read 00b for a 32-bit window and 10b for a 64-bit window, and bit 3 reads the prefetchable flag. Writes do not change these bits.
- R4: Address bits below log2(size) read 0 on a memory slot. A 4 KB non-prefetchable 32-bit window reads FFFF_F000h after an all-ones write. A 16-byte prefetchable 32-bit window reads FFFF_FFF8h.
- R5: On an I/O slot, bit 1 reads 0 and the bits from log2(size) upward are writable. A 256-byte I/O slot reads FFFF_FF01h after an all-ones write.
- R6: A 64-bit window starts on an even slot, and the following slot carries base bits [63:32]. That following slot has all 32 bits writable and no attribute bits. The exported base of the lower slot is {upper slot, lower slot address bits}, and the exported base of the upper slot is 0.
- R7: An unused slot reads 0000_0000h whatever is written to it, and its exported base and size are 0.
- R8: In the ROM register, bits from log2(ROM size) up to 31 are writable, the bits between bit 0 and log2(ROM size) read 0, and bit 0 is a writable enable. The ROM enable output follows bit 0, and the ROM base output is the register with bit 0 cleared.
- R9: A write updates only the byte lanes whose enable is set. Lane k covers data bits [8k+7:8k].
- R10: Reset clears every writable bit, so each slot then reads only its attribute bits and every exported base and the ROM enable read 0.
- R11: The size output of a slot is log2(size) for a 32-bit window, the lower slot of a 64-bit window and an I/O slot. It is 0 for an upper slot and for an unused slot. The ROM size output is log2(ROM size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr | input | CFG_AW | Configuration dword index |
| cfg_wr_en | input | 1 | Write strobe, one cycle per write |
| cfg_be | input | 4 | Byte lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| bar_base_o | output | 6*64 | Programmed 64-bit base per slot, slot n at bits [64n+63:64n] |
| bar_size_o | output | 6*6 | log2 window size per slot, slot n at bits [6n+5:6n] |
| rom_base_o | output | 32 | ROM base address with the enable bit cleared |
| rom_en_o | output | 1 | ROM decode enable |
| rom_size_o | output | 6 | log2 of the ROM size |

## Verification
The bench uses the default parameter set, which holds every slot kind in a single instance. Slot 0 is a 4 KB non-prefetchable 32-bit window, slot 1 is a 256-byte I/O window, and slots 2 and 3 form a 64 MB prefetchable 64-bit pair. Slot 4 is unused, slot 5 is a 16-byte prefetchable 32-bit window, and the ROM is 64 KB. With this layout the all-ones sizing reads of every encoding, the joining of a pair, the minimum memory size and the reads of an unused slot can all be reached. Random writes with random lane enables over indices 3 to 13 also touch the unmapped indices next to each region.

// File: rtl/bar_pkg.sv
`timescale 1ns/1ps
package bar_pkg;

  localparam int NUM_SLOTS     = 6;
  localparam int SLOT_BASE_IDX = 4;   // dword index of slot 0 (byte 10h)
  localparam int ROM_IDX       = 12;  // dword index of ROM register (byte 30h)

  // two-bit per-slot kind encoding used by the top-level parameter
  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_MEM32 = 2'd1;
  localparam logic [1:0] KIND_MEM64 = 2'd2;
  localparam logic [1:0] KIND_IO    = 2'd3;

  typedef enum logic [2:0] {
    ROLE_OFF,
    ROLE_MEM32,
    ROLE_MEM64LO,
    ROLE_MEM64HI,
    ROLE_IO
  } slot_role_e;

  // Resolve what a slot does from the full kind vector: an odd slot that
  // follows a 64-bit start becomes the upper half regardless of its own kind.
  function automatic slot_role_e role_of(input logic [2*NUM_SLOTS-1:0] kinds,
                                         input int idx);
    logic [1:0] k;
    k = kinds[2*idx +: 2];
    if (idx % 2 == 1) begin
      if (kinds[2*(idx-1) +: 2] == KIND_MEM64) return ROLE_MEM64HI;
    end
    case (k)
      KIND_MEM32: return ROLE_MEM32;
      KIND_MEM64: return ROLE_MEM64LO;
      KIND_IO:    return ROLE_IO;
      default:    return ROLE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/bar_slot.sv
`timescale 1ns/1ps
module bar_slot
  import bar_pkg::*;
#(
  parameter slot_role_e ROLE      = ROLE_OFF,
  parameter int         SIZE_LOG2 = 4,
  parameter bit         PREF      = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata_o,
  output logic [31:0] addr_o
);

  // bits software may change
  localparam logic [31:0] WMASK =
    (ROLE == ROLE_OFF)     ? 32'h0000_0000 :
    (ROLE == ROLE_MEM64HI) ? 32'hFFFF_FFFF :
                             (32'hFFFF_FFFF << SIZE_LOG2);

  // hardwired attribute bits merged into reads
  localparam logic [31:0] ATTR =
    (ROLE == ROLE_IO)      ? 32'h0000_0001 :
    (ROLE == ROLE_MEM32)   ? {28'h0, PREF, 3'b000} :
    (ROLE == ROLE_MEM64LO) ? {28'h0, PREF, 3'b100} :
                             32'h0000_0000;

  logic [31:0] lane_m;
  logic [31:0] q;

  always_comb begin
    for (int k = 0; k < 4; k++) lane_m[k*8 +: 8] = {8{be[k]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= (q & ~(lane_m & WMASK)) | (wdata & lane_m & WMASK);
    end
  end

  assign addr_o  = q;
  assign rdata_o = q | ATTR;

  // a full-lane write lands exactly the writable part of the data
  a_r4_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be == 4'hF) |=> (q == ($past(wdata) & WMASK)));

  for (genvar k = 0; k < 4; k++) begin : g_lane_chk
    // disabled lanes keep their contents
    a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[k]) |=> $stable(q[k*8 +: 8]));
  end

endmodule

// File: rtl/bar_rom.sv
`timescale 1ns/1ps
module bar_rom #(
  parameter bit PRESENT   = 1'b1,
  parameter int SIZE_LOG2 = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata_o,
  output logic [31:0] base_o,
  output logic        en_o
);

  localparam logic [31:0] WMASK =
    PRESENT ? ((32'hFFFF_FFFF << SIZE_LOG2) | 32'h1) : 32'h0;

  logic [31:0] lane_m;
  logic [31:0] q;

  always_comb begin
    for (int k = 0; k < 4; k++) lane_m[k*8 +: 8] = {8{be[k]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= (q & ~(lane_m & WMASK)) | (wdata & lane_m & WMASK);
    end
  end

  assign rdata_o = q;
  assign base_o  = {q[31:1], 1'b0};
  assign en_o    = q[0];

  // decode enable only turns on through a write setting bit 0
  a_r8_en_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o) |-> $past(wr_en && be[0] && wdata[0]));

endmodule

// File: rtl/bar_rdmux.sv
`timescale 1ns/1ps
module bar_rdmux
  import bar_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0]                  addr,
  input  logic [NUM_SLOTS-1:0][31:0]     slot_rd,
  input  logic [31:0]                    rom_rd,
  output logic [31:0]                    rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (addr == AW'(SLOT_BASE_IDX + i)) rdata = slot_rd[i];
    end
    if (addr == AW'(ROM_IDX)) rdata = rom_rd;
  end

endmodule

// File: rtl/ep_bar_bank.sv
`timescale 1ns/1ps
module ep_bar_bank
  import bar_pkg::*;
#(
  parameter int                         CFG_AW        = 10,
  // slot n kind at bits [2n+1:2n]: 0 unused, 1 mem32, 2 mem64, 3 io
  parameter logic [2*NUM_SLOTS-1:0]     SLOT_KIND     = {2'd1, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1},
  // slot n log2 size at bits [6n+5:6n]
  parameter logic [6*NUM_SLOTS-1:0]     SLOT_SIZE     = {6'd4, 6'd0, 6'd0, 6'd26, 6'd8, 6'd12},
  parameter logic [NUM_SLOTS-1:0]       SLOT_PREF     = 6'b100100,
  parameter bit                         ROM_PRESENT   = 1'b1,
  parameter int                         ROM_SIZE_LOG2 = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic                     cfg_wr_en,
  input  logic [3:0]               cfg_be,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output logic [NUM_SLOTS*64-1:0]  bar_base_o,
  output logic [NUM_SLOTS*6-1:0]   bar_size_o,
  output logic [31:0]              rom_base_o,
  output logic                     rom_en_o,
  output logic [5:0]               rom_size_o
);

  logic [NUM_SLOTS-1:0]        slot_wr;
  logic [NUM_SLOTS-1:0][31:0]  slot_rd;
  logic [NUM_SLOTS-1:0][31:0]  slot_addr;
  logic [31:0]                 rom_rd;
  logic                        rom_wr;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam slot_role_e RL = role_of(SLOT_KIND, i);
    localparam int         SZ = int'(SLOT_SIZE[i*6 +: 6]);

    // layout legality, checked at elaboration
    if (RL == ROLE_MEM64LO && (i % 2) != 0) begin : g_bad_odd
      $error("64-bit window must start on an even slot");
    end
    if (RL == ROLE_MEM64HI && SLOT_KIND[2*i +: 2] != KIND_NONE) begin : g_bad_upper
      $error("slot after a 64-bit start must be declared unused");
    end
    if ((RL == ROLE_MEM32 || RL == ROLE_MEM64LO) && (SZ < 4 || SZ > 31)) begin : g_bad_msize
      $error("memory window size out of range");
    end
    if (RL == ROLE_IO && (SZ < 2 || SZ > 31)) begin : g_bad_isize
      $error("io window size out of range");
    end

    assign slot_wr[i] = cfg_wr_en && (cfg_addr == CFG_AW'(SLOT_BASE_IDX + i));

    bar_slot #(
      .ROLE      (RL),
      .SIZE_LOG2 (SZ),
      .PREF      (SLOT_PREF[i])
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (slot_wr[i]),
      .be      (cfg_be),
      .wdata   (cfg_wdata),
      .rdata_o (slot_rd[i]),
      .addr_o  (slot_addr[i])
    );

    if (RL == ROLE_MEM64LO) begin : g_pair
      assign bar_base_o[i*64 +: 64] = {slot_addr[i+1], slot_addr[i]};
      assign bar_size_o[i*6 +: 6]   = 6'(SZ);
      // upper half of exported base tracks the neighbouring slot register
      a_r6_pair_base: assert property (@(posedge clk) disable iff (!rst_n)
        bar_base_o[i*64+32 +: 32] == slot_rd[i+1]);
    end else if (RL == ROLE_MEM32 || RL == ROLE_IO) begin : g_single
      assign bar_base_o[i*64 +: 64] = {32'h0, slot_addr[i]};
      assign bar_size_o[i*6 +: 6]   = 6'(SZ);
    end else begin : g_none
      assign bar_base_o[i*64 +: 64] = 64'h0;
      assign bar_size_o[i*6 +: 6]   = 6'h0;
    end
  end

  if (ROM_PRESENT && (ROM_SIZE_LOG2 < 11 || ROM_SIZE_LOG2 > 31)) begin : g_bad_rom
    $error("ROM size out of range");
  end

  assign rom_wr     = cfg_wr_en && (cfg_addr == CFG_AW'(ROM_IDX));
  assign rom_size_o = ROM_PRESENT ? 6'(ROM_SIZE_LOG2) : 6'h0;

  bar_rom #(
    .PRESENT   (ROM_PRESENT),
    .SIZE_LOG2 (ROM_SIZE_LOG2)
  ) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rom_wr),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .rdata_o (rom_rd),
    .base_o  (rom_base_o),
    .en_o    (rom_en_o)
  );

  bar_rdmux #(.AW(CFG_AW)) u_rdmux (
    .addr    (cfg_addr),
    .slot_rd (slot_rd),
    .rom_rd  (rom_rd),
    .rdata   (cfg_rdata)
  );

  // an index outside the bank never returns data
  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < CFG_AW'(SLOT_BASE_IDX) || cfg_addr > CFG_AW'(ROM_IDX)) |-> cfg_rdata == 32'h0);

endmodule

// File: tb/ep_bar_bank_tb_top.sv
`timescale 1ns/1ps
module ep_bar_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [383:0] bar_base_o;
  logic [35:0] bar_size_o;
  logic [31:0] rom_base_o;
  logic        rom_en_o;
  logic [5:0]  rom_size_o;

  always #4 clk = ~clk;  // 125 MHz

  ep_bar_bank dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bar_base_o(bar_base_o), .bar_size_o(bar_size_o), .rom_base_o(rom_base_o),
    .rom_en_o(rom_en_o), .rom_size_o(rom_size_o)
  );

  // bench view of the layout: 0 unused, 1 mem32, 2 mem64, 3 io
  int kind [6] = '{1, 3, 2, 0, 0, 1};
  int lsz  [6] = '{12, 8, 26, 0, 0, 4};
  int pref [6] = '{0, 0, 1, 0, 0, 1};

  logic [31:0] m_slot [6];
  logic [31:0] m_rom;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic bit is_upper(int i);
    return (i % 2 == 1) && kind[i-1] == 2;
  endfunction
  function automatic logic [31:0] wmask(int i);
    if (is_upper(i)) return 32'hFFFF_FFFF;
    if (kind[i] == 0) return 32'h0;
    return 32'hFFFF_FFFF << lsz[i];
  endfunction
  function automatic logic [31:0] attr(int i);
    if (is_upper(i)) return 32'h0;
    case (kind[i])
      1: return pref[i] ? 32'h8 : 32'h0;
      2: return pref[i] ? 32'hC : 32'h4;
      3: return 32'h1;
      default: return 32'h0;
    endcase
  endfunction
  function automatic logic [31:0] exp_rd(int a);
    if (a >= 4 && a <= 9) return m_slot[a-4] | attr(a-4);
    if (a == 12) return m_rom;
    return 32'h0;
  endfunction
  function automatic logic [63:0] exp_base(int i);
    if (is_upper(i) || kind[i] == 0) return 64'h0;
    if (kind[i] == 2) return {m_slot[i+1], m_slot[i]};
    return {32'h0, m_slot[i]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updated on the same edge as the design
  always @(posedge clk) begin
    logic [31:0] lm;
    int a;
    for (int k = 0; k < 4; k++) lm[k*8 +: 8] = {8{cfg_be[k]}};
    a = int'(cfg_addr);
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_slot[i] = '0;
      m_rom = '0;
    end else if (cfg_wr_en) begin
      if (a >= 4 && a <= 9)
        m_slot[a-4] = (m_slot[a-4] & ~(lm & wmask(a-4))) | (cfg_wdata & lm & wmask(a-4));
      else if (a == 12) begin
        lm = lm & ((32'hFFFF_FFFF << 16) | 32'h1);
        m_rom = (m_rom & ~lm) | (cfg_wdata & lm);
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 read data", {32'h0, cfg_rdata}, {32'h0, exp_rd(int'(cfg_addr))});
      for (int i = 0; i < 6; i++)
        chk("R6 exported base", bar_base_o[i*64 +: 64], exp_base(i));
      chk("R8 rom outputs", {31'h0, rom_en_o, rom_base_o}, {31'h0, m_rom[0], m_rom & 32'hFFFF_FFFE});
    end
  end

  task automatic wr(int a, logic [3:0] b, logic [31:0] d);
    cfg_addr = 10'(a); cfg_be = b; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [31:0] e, string tag);
    cfg_addr = 10'(a);
    #2;
    chk(tag, {32'h0, cfg_rdata}, {32'h0, e});
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R10 reset state: attribute bits only, R2/R3 encodings
    rd_chk(4, 32'h0000_0000, "R10 slot0 reset");
    rd_chk(5, 32'h0000_0001, "R2 io bit0 after reset");
    rd_chk(6, 32'h0000_000C, "R3 64-bit prefetchable attr");
    rd_chk(7, 32'h0000_0000, "R6 upper slot reset");
    rd_chk(9, 32'h0000_0008, "R3 32-bit prefetchable attr");
    rd_chk(12, 32'h0000_0000, "R10 rom reset");
    chk("R10 bases zero", {63'h0, |bar_base_o}, 64'h0);
    chk("R10 rom enable zero", {63'h0, rom_en_o}, 64'h0);

    // R11 sizes
    chk("R11 slot sizes", {28'h0, bar_size_o}, {28'h0, 6'd4, 6'd0, 6'd0, 6'd26, 6'd8, 6'd12});
    chk("R11 rom size", {58'h0, rom_size_o}, 64'd16);

    // sizing: all-ones everywhere
    for (int a = 4; a <= 9; a++) wr(a, 4'hF, 32'hFFFF_FFFF);
    wr(12, 4'hF, 32'hFFFF_FFFF);
    rd_chk(4, 32'hFFFF_F000, "R4 4KB mem32 sizing");
    rd_chk(5, 32'hFFFF_FF01, "R5 256B io sizing");
    rd_chk(6, 32'hFC00_000C, "R6 64MB lower sizing");
    rd_chk(7, 32'hFFFF_FFFF, "R6 upper all writable");
    rd_chk(8, 32'h0000_0000, "R7 unused slot");
    rd_chk(9, 32'hFFFF_FFF8, "R4 16B minimum size");
    rd_chk(12, 32'hFFFF_0001, "R8 rom sizing");
    chk("R7 unused base", bar_base_o[4*64 +: 64], 64'h0);

    // R1 writes to neighbouring indices change nothing
    wr(3, 4'hF, 32'h0);
    wr(10, 4'hF, 32'h0);
    wr(13, 4'hF, 32'h0);
    rd_chk(3, 32'h0, "R1 index 3 zero");
    rd_chk(11, 32'h0, "R1 index 11 zero");
    rd_chk(9, 32'hFFFF_FFF8, "R1 slot5 untouched");

    // R2/R3 attribute bits survive zero writes
    wr(5, 4'hF, 32'h0);
    rd_chk(5, 32'h0000_0001, "R2 io bit0 read-only");
    wr(6, 4'hF, 32'h0000_0000);
    rd_chk(6, 32'h0000_000C, "R3 memory attrs read-only");

    // R6 program a pair above 4 GB
    wr(6, 4'hF, 32'h4000_000F);
    wr(7, 4'hF, 32'h0000_0002);
    chk("R6 joined base", bar_base_o[2*64 +: 64], 64'h0000_0002_4000_0000);
    chk("R6 upper slot base", bar_base_o[3*64 +: 64], 64'h0);

    // R8 ROM base then enable via lane 0 only
    wr(12, 4'hF, 32'h00C0_0000);
    chk("R8 rom disabled", {63'h0, rom_en_o}, 64'h0);
    wr(12, 4'h1, 32'hFFFF_FFFF);
    chk("R8 rom enabled", {31'h0, rom_en_o, rom_base_o}, {31'h0, 1'b1, 32'h00C0_0000});

    // R9 single lane write
    wr(4, 4'h4, 32'hAABB_CCDD);
    rd_chk(4, 32'hFFBB_F000, "R9 lane 2 only");

    // random traffic against the model
    r = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      if (r[3]) wr(3 + int'(r[15:8] % 8'd11), r[23:20], {r[7:0], r[31:8]});
      else rd_chk(3 + int'(r[15:8] % 8'd11), exp_rd(3 + int'(r[15:8] % 8'd11)), "R9 random read");
    end

    // R10 reset mid-run
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd_chk(4, 32'h0, "R10 slot0 after reset");
    rd_chk(6, 32'h0000_000C, "R10 pair after reset");
    chk("R10 bases after reset", {63'h0, |bar_base_o}, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule